// File: doc/BRIEF.md
# Channel-Ordered Sample Buffer with Programmable Trigger

This block sits between a converter that produces samples and a processor that reads them over a simple strobe bus. Samples enter on a valid/ready stream and go into a 16-entry, 10-bit first-in first-out store. The source interleaves its channels in a fixed rotation, so the reader can tell channels apart by their position in the read sequence. A data-available output tells the processor that enough samples have built up. The threshold comes from a 2-bit trigger code, and its meaning changes with the number of active channels. Differential and single-ended inputs each count as one channel.

The processor side has two chip selects, one active low and one active high, plus a read strobe and a write strobe. The bus is asynchronous to the core clock. An access is live only while both chip selects are asserted, its own strobe is asserted and the opposite strobe is inactive. A read drives the oldest word onto the data bus and removes it when the strobe is released. A write loads one of two small configuration registers. A configuration bit turns the write pin into a combined direction line. In that mode the chip selects alone frame the access, the line's level chooses read or write, and the read pin has no effect.

Back-pressure on the sample stream: `smp_ready` is high whenever the store has room. A beat with `smp_valid` high while `smp_ready` is low is not stored. It is lost and it sets the sticky overrun flag, so the source does not need to hold it.

Top module: `cbuf_top`

## Requirements
- R1: After reset the store is empty, `smp_ready` is 1, `dav` is 0, both sticky flags are 0, `rdata_oe` is 0, and both configuration registers are zero.
- R2: Every accepted sample (`smp_valid` and `smp_ready` both high at a clock edge) is returned by successive reads in arrival order.
- R3: With 16 samples stored, `smp_ready` is 0. A further beat is discarded, the stored contents are unchanged, and `ovr_flag` goes to 1 and stays there until reset.
- R4: A read while the store is empty presents the last value removed, removes nothing, and sets `und_flag`, which stays set until reset.
- R5: The threshold is chosen by config register 1 bits 3:2 (code) and config register 0 bits 1:0 (active channels minus one). For 1 channel, codes 0..3 give 1, 4, 8, 14. For 2 channels they give 2, 4, 8, 12. For 3 channels: 3, 6, 9, 12. For 4 channels: 4, 8, 12, and code 3 is reserved. Data is available when the stored count is at least the threshold.
- R6: With 4 channels and code 3 selected, `dav` stays at its inactive level whatever the fill.
- R7: Config register 1 bit 0 sets the `dav` polarity: 0 means active high and 1 means active low.
- R8: In separate-strobe mode, a read is live only while `cs0_n`=0, `cs1`=1, `rd_n`=0 and `wr_n`=1. While live, `rdata_oe` is 1 and `rdata` shows the oldest word. Exactly one word is removed after the read is released.
- R9: In separate-strobe mode, a write is live only while `cs0_n`=0, `cs1`=1, `wr_n`=0 and `rd_n`=1. `addr` selects register 0 (which takes `wdata[1:0]`) or register 1 (which takes `wdata[3:0]`).
- R10: With config register 1 bit 1 set, `wr_n` acts as the direction line (1 = read, 0 = write) inside a chip-select frame, and `rd_n` is ignored.
- R11: If either chip select is inactive, the strobes have no effect: `rdata_oe` stays 0 and nothing is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Store has room |
| smp_data | input | 10 | Sample value |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, or direction line |
| addr | input | 1 | Config register select |
| wdata | input | 4 | Config write data |
| rdata | output | 10 | Read data |
| rdata_oe | output | 1 | Read data drive enable |
| dav | output | 1 | Data available, programmable polarity |
| ovr_flag | output | 1 | Sticky overrun |
| und_flag | output | 1 | Sticky underrun |

## Verification
The threshold is tested with three patterns. The first is one channel at code 0, where a single sample is enough. The second is three channels at code 1, where the fill goes from 5 to 6 and the flag must change exactly at the sixth sample. The third is four channels, where the same fill of 12 must read as inactive under the reserved code and as active under code 2, which separates the reserved case from the ordinary table. Read-order checks use distinct values, so a dropped, duplicated or reordered word shows up. A read framed by only one chip select must leave the next read's value unchanged. In combined mode the read pin is held at its asserting level during a write and at its inactive level during a read, which shows that only the direction line decides.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  localparam int LVL_W = 5;

  typedef struct packed {
    logic             reserved;
    logic [LVL_W-1:0] level;
  } trig_t;

  // threshold by active-channel count (minus one) and trigger code
  function automatic trig_t trig_lookup(input logic [1:0] nch_m1, input logic [1:0] code);
    trig_t t;
    t.reserved = 1'b0;
    t.level    = '0;
    unique case (nch_m1)
      2'd0: case (code) 2'd0: t.level = 5'd1; 2'd1: t.level = 5'd4; 2'd2: t.level = 5'd8; default: t.level = 5'd14; endcase
      2'd1: case (code) 2'd0: t.level = 5'd2; 2'd1: t.level = 5'd4; 2'd2: t.level = 5'd8; default: t.level = 5'd12; endcase
      2'd2: case (code) 2'd0: t.level = 5'd3; 2'd1: t.level = 5'd6; 2'd2: t.level = 5'd9; default: t.level = 5'd12; endcase
      default: case (code)
        2'd0: t.level = 5'd4; 2'd1: t.level = 5'd8; 2'd2: t.level = 5'd12;
        default: t.reserved = 1'b1;
      endcase
    endcase
    return t;
  endfunction
endpackage

// File: rtl/cbuf_bus_if.sv
module cbuf_bus_if #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs0_n,
  input  logic cs1,
  input  logic rd_n,
  input  logic wr_n,
  input  logic rw_combined,
  output logic rd_live,
  output logic pop_pulse,
  output logic wr_pulse
);
  logic frame, wr_live;
  logic [SYNC:0] rd_sh, wr_sh;

  assign frame   = !cs0_n && cs1;
  assign rd_live = rw_combined ? (frame && wr_n)  : (frame && !rd_n && wr_n);
  assign wr_live = rw_combined ? (frame && !wr_n) : (frame && !wr_n && rd_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh <= '0;
      wr_sh <= '0;
    end else begin
      rd_sh <= {rd_sh[SYNC-1:0], rd_live};
      wr_sh <= {wr_sh[SYNC-1:0], wr_live};
    end
  end

  // pop on release of the read, load on start of the write
  assign pop_pulse = !rd_sh[SYNC-1] && rd_sh[SYNC];
  assign wr_pulse  = wr_sh[SYNC-1] && !wr_sh[SYNC];

  assert_single_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_pulse |=> !pop_pulse);
  assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !pop_pulse);
endmodule

// File: rtl/cbuf_fifo.sv
module cbuf_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          ovr,
  output logic          und
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [W-1:0]  last_q;
  logic          empty, full, do_push, do_pop;

  assign empty      = (count == '0);
  assign full       = (count == CW'(DEPTH));
  assign push_ready = !full;
  assign do_push    = push_valid && !full;
  assign do_pop     = pop && !empty;
  assign head       = empty ? last_q : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; last_q <= '0; ovr <= 1'b0; und <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop) begin
        rp     <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
        last_q <= mem[rp];
      end
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push_valid && full) ovr <= 1'b1;
      if (pop && empty)       und <= 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop) |=> ($stable(count) && ovr));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> und);
  assert_sticky_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(und) |-> und);
endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pulse,
  input  logic             addr,
  input  logic [CFG_W-1:0] wdata,
  output logic [1:0]       nch_m1,
  output logic [1:0]       trig_code,
  output logic             dav_low,
  output logic             rw_combined
);
  logic [1:0]       reg0;
  logic [CFG_W-1:0] reg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg0 <= '0;
      reg1 <= '0;
    end else if (wr_pulse) begin
      if (addr) reg1 <= wdata;
      else      reg0 <= wdata[1:0];
    end
  end

  assign nch_m1      = reg0;
  assign trig_code   = reg1[3:2];
  assign rw_combined = reg1[1];
  assign dav_low     = reg1[0];

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> ($stable(reg0) && $stable(reg1)));
endmodule

// File: rtl/cbuf_top.sv
module cbuf_top #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  parameter int CFG_W = 4,
  parameter int SYNC  = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [W-1:0]     smp_data,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             addr,
  input  logic [CFG_W-1:0] wdata,
  output logic [W-1:0]     rdata,
  output logic             rdata_oe,
  output logic             dav,
  output logic             ovr_flag,
  output logic             und_flag
);
  import cbuf_pkg::*;

  logic          pop_pulse, wr_pulse, rw_combined, dav_low, dav_hit;
  logic [1:0]    nch_m1, trig_code;
  logic [CW-1:0] count;
  trig_t         trig;

  cbuf_bus_if #(.SYNC(SYNC)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .rd_n(rd_n), .wr_n(wr_n),
    .rw_combined(rw_combined), .rd_live(rdata_oe), .pop_pulse(pop_pulse), .wr_pulse(wr_pulse)
  );

  cbuf_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .addr(addr), .wdata(wdata),
    .nch_m1(nch_m1), .trig_code(trig_code), .dav_low(dav_low), .rw_combined(rw_combined)
  );

  cbuf_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(smp_valid), .push_ready(smp_ready),
    .push_data(smp_data), .pop(pop_pulse), .head(rdata), .count(count),
    .ovr(ovr_flag), .und(und_flag)
  );

  assign trig    = trig_lookup(nch_m1, trig_code);
  assign dav_hit = !trig.reserved && (32'(count) >= 32'(trig.level));
  assign dav     = dav_hit ^ dav_low;

  assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nch_m1 == 2'd3 && trig_code == 2'd3) |-> (dav == dav_low));
  assert_empty_no_dav_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (dav == dav_low));
endmodule

// File: tb/cbuf_top_test.sv
module cbuf_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, cs0_n = 1'b1, cs1 = 1'b0, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [9:0] smp_data = '0;
  logic [3:0] wdata = '0;
  logic smp_ready, rdata_oe, dav, ovr_flag, und_flag;
  logic [9:0] rdata;

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  logic [9:0] last_exp = '0;
  bit done = 0;

  always #4 clk = ~clk;

  cbuf_top uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .cs0_n(cs0_n), .cs1(cs1), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .dav(dav), .ovr_flag(ovr_flag), .und_flag(und_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: offers one beat, records it if accepted
  task automatic push(input logic [9:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    if (smp_ready) exp_q.push_back(d);
    @(negedge clk);
    smp_valid = 1'b0;
    idle(1);
  endtask

  task automatic bus_write(input logic a, input logic [3:0] d, input bit comb, input logic rdlvl);
    @(negedge clk);
    addr = a; wdata = d; cs0_n = 1'b0; cs1 = 1'b1; rd_n = comb ? rdlvl : 1'b1; wr_n = 1'b0;
    idle(5);
    wr_n = 1'b1; cs0_n = 1'b1; cs1 = 1'b0; rd_n = 1'b1;
    idle(3);
  endtask

  // monitor side of the scoreboard: compares the presented word, then releases
  task automatic bus_read(input string req, input bit comb, input logic rdlvl);
    logic [9:0] e;
    @(negedge clk);
    cs0_n = 1'b0; cs1 = 1'b1; wr_n = 1'b1; rd_n = comb ? rdlvl : 1'b0;
    idle(3);
    check({req, " oe"}, int'(rdata_oe), 1);
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); last_exp = e; end
    else e = last_exp;
    check({req, " data"}, int'(rdata), int'(e));
    cs0_n = 1'b1; cs1 = 1'b0; rd_n = 1'b1;
    idle(6);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    check("R1 ready", int'(smp_ready), 1);
    check("R1 dav", int'(dav), 0);
    check("R1 ovr", int'(ovr_flag), 0);
    check("R1 und", int'(und_flag), 0);
    check("R1 oe", int'(rdata_oe), 0);

    // R5 one channel, code 0: level 1
    push(10'h155); idle(1);
    check("R5 1ch lvl1", int'(dav), 1);
    bus_read("R8 R2 single", 0, 1'b0);
    check("R8 one pop", int'(dav), 0);

    // R4 empty read returns last value
    bus_read("R4 empty read", 0, 1'b0);
    check("R4 und", int'(und_flag), 1);

    // R5 three channels, code 1: level 6
    bus_write(1'b0, 4'd2, 0, 1'b1);
    bus_write(1'b1, 4'b0100, 0, 1'b1);
    for (int i = 0; i < 5; i++) push(10'(100 + i));
    check("R5 3ch below", int'(dav), 0);
    push(10'd105); idle(1);
    check("R5 3ch at 6", int'(dav), 1);
    bus_write(1'b1, 4'b0101, 0, 1'b1);
    check("R7 active low", int'(dav), 0);
    bus_write(1'b1, 4'b0100, 0, 1'b1);
    check("R7 back high", int'(dav), 1);
    for (int i = 0; i < 6; i++) bus_read("R2 3ch order", 0, 1'b0);

    // R6 four channels reserved code, then code 2 (level 12)
    bus_write(1'b0, 4'd3, 0, 1'b1);
    bus_write(1'b1, 4'b1100, 0, 1'b1);
    for (int i = 0; i < 12; i++) push(10'(200 + 7 * i));
    check("R6 reserved", int'(dav), 0);
    bus_write(1'b1, 4'b1000, 0, 1'b1);
    check("R5 4ch lvl12", int'(dav), 1);

    // R11 one chip select missing
    @(negedge clk);
    cs0_n = 1'b0; cs1 = 1'b0; rd_n = 1'b0;
    idle(4);
    check("R11 oe", int'(rdata_oe), 0);
    rd_n = 1'b1; cs0_n = 1'b1;
    idle(6);
    check("R11 no pop", int'(dav), 1);
    for (int i = 0; i < 12; i++) bus_read("R11 R2 4ch order", 0, 1'b0);

    // R3 overflow
    bus_write(1'b0, 4'd0, 0, 1'b1);
    bus_write(1'b1, 4'd0, 0, 1'b1);
    for (int i = 0; i < 16; i++) push(10'(512 + 3 * i));
    check("R3 not ready", int'(smp_ready), 0);
    check("R3 ovr clear", int'(ovr_flag), 0);
    push(10'h3FF);
    check("R3 ovr", int'(ovr_flag), 1);
    for (int i = 0; i < 16; i++) bus_read("R3 contents", 0, 1'b0);
    check("R3 ovr sticky", int'(ovr_flag), 1);

    // R10 combined direction line; rd_n held low during write, high during read
    bus_write(1'b1, 4'b0010, 0, 1'b1);
    bus_write(1'b0, 4'd1, 1, 1'b0);
    push(10'd33); idle(1);
    check("R10 2ch below", int'(dav), 0);
    push(10'd44); idle(1);
    check("R10 2ch lvl2", int'(dav), 1);
    bus_read("R10 comb read", 1, 1'b1);
    bus_read("R10 comb read", 1, 1'b1);
    check("R10 drained", int'(dav), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule